// File: doc/BRIEF.md
# Interruption Entry State Sequencer

This block performs the entry sequence a processor core runs once it has accepted an interruption with a cause number. Starting from the cause and a snapshot of the machine state, it drives one register write per cycle on a single write port. The sequence preserves the running processor status word, installs a fresh status word, and records where execution was by capturing the front and back entries of the instruction space and offset queues. When the old status word has its state-collection bit set, it also copies seven general registers into shadow registers. In its final cycle it presents the redirected instruction queues.

The surrounding core supplies the cause number, the current status word, the instruction queues, the already-formed global virtual addresses of the queue heads, the vector base register and a combinational general-register read port. The core applies each write strobe to its own register files and loads the redirect values into its fetch queues. A parameter selects the 32-bit or the 64-bit architecture variant. This choice changes how space identifiers are captured and whether the wide bit may appear in the new status word.

Top module: `ient_seq`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` is high and `busy` is low. `req_ready` equals the inverse of `busy`. `busy` stays high from the cycle after acceptance up to and including the single cycle in which `done` pulses, then drops. Requests and input changes made while busy are ignored, because all inputs are sampled only at acceptance.
- R2: The first busy cycle writes the sampled status word to the saved-status target (`wr_sel` 0).
- R3: The second busy cycle writes the new status word (`wr_sel` 1). It is zero except in two places. Bit 27 (wide) is set when the variant is 64-bit and `psw_dflt_wide` was high. Bit 4 (machine-check mask) is set only for cause 1.
- R4: Space capture uses `wr_sel` 2 for the front entry and 3 for the back entry. In the 32-bit variant the captured value is bits 63:32 of the space queue entry. In the 64-bit variant it is bits 63:32 of the formed global virtual address when old status bit 18 (translation) is set, and zero otherwise. The value is zero-extended in both cases.
- R5: The sampled front and back offset queue entries are written to `wr_sel` 4 and 5.
- R6: When old status bit 3 (state collection) is set, seven further cycles copy general registers 1, 8, 9, 16, 17, 24 and 25, in that order, to shadow targets `wr_sel` 6 to 12. `gr_raddr` names the register being read in each of these cycles. When the bit is clear, no shadow write occurs.
- R7: For a cause other than 63, the redirected front offset is the vector base plus 32 times the cause, modulo 2^64.
- R8: For cause 63 (transfer of control), the redirected front offset is the firmware start parameter. Two extra cycles then write the captured back space value to `wr_sel` 13 and the sampled back offset to `wr_sel` 14.
- R9: In the `done` cycle, `redir_valid` is high, the back offset is the front offset plus 4, and both redirected space entries are zero.
- R10: The number of busy cycles is 7, plus 7 when state collection is set, plus 2 for cause 63. The writes appear in the order 0..5, then the shadow writes, then 13 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interruption request |
| req_ready | output | 1 | Block can accept a request |
| req_cause | input | CAUSE_W | Cause number |
| psw_cur | input | DW | Current status word |
| psw_dflt_wide | input | 1 | Default status wide bit |
| iasq_front | input | DW | Front space queue entry |
| iasq_back | input | DW | Back space queue entry |
| iaoq_front | input | DW | Front offset queue entry |
| iaoq_back | input | DW | Back offset queue entry |
| gva_front | input | DW | Formed global virtual address, front |
| gva_back | input | DW | Formed global virtual address, back |
| vec_base | input | DW | Interruption vector base |
| gr_raddr | output | 5 | General register read address |
| gr_rdata | input | DW | General register read data |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 5 | Write target code |
| wr_data | output | DW | Write data |
| redir_valid | output | 1 | Redirect values valid |
| redir_oq_front | output | DW | New front offset |
| redir_oq_back | output | DW | New back offset |
| redir_sq_front | output | DW | New front space |
| redir_sq_back | output | DW | New back space |
| busy | output | 1 | Sequence running |
| done | output | 1 | Final cycle pulse |

## Verification
Random causes, status words and queue contents cover every combination of the state-collection and translation bits. Each random pattern separates sequences with and without shadow copies, and with and without the translated space capture. Directed cases take cause 1 (the machine-check mask alone), cause 63 with the collection bit both set and clear (the firmware target and the two extra writes), and cause 62 with a vector base near wrap-around (the modular vector sum). A second instance built as the 32-bit variant runs on the same stimulus, which shows the variant-specific space capture and the suppressed wide bit. During every sequence the inputs are changed and the request is held high, which shows that only the values sampled at acceptance are used.

// File: rtl/ient_pkg.sv
package ient_pkg;

  localparam int PSW_BIT_Q = 3;
  localparam int PSW_BIT_M = 4;
  localparam int PSW_BIT_C = 18;
  localparam int PSW_BIT_W = 27;
  localparam int NUM_SHADOW = 7;
  localparam int SEL_W = 5;
  localparam int GR_AW = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SAVE, ST_LOAD, ST_SQF, ST_SQB, ST_OQF, ST_OQB,
    ST_SHADOW, ST_TOC_SP, ST_TOC_OF, ST_REDIR
  } ient_state_e;

  typedef enum logic [SEL_W-1:0] {
    TGT_IPSW    = 5'd0,
    TGT_PSW     = 5'd1,
    TGT_SQ_F    = 5'd2,
    TGT_SQ_B    = 5'd3,
    TGT_OQ_F    = 5'd4,
    TGT_OQ_B    = 5'd5,
    TGT_SHADOW0 = 5'd6,
    TGT_GR24    = 5'd13,
    TGT_GR25    = 5'd14
  } ient_tgt_e;

  // Source register for each shadow slot.
  function automatic logic [GR_AW-1:0] shadow_src(input logic [2:0] slot);
    case (slot)
      3'd0: shadow_src = 5'd1;
      3'd1: shadow_src = 5'd8;
      3'd2: shadow_src = 5'd9;
      3'd3: shadow_src = 5'd16;
      3'd4: shadow_src = 5'd17;
      3'd5: shadow_src = 5'd24;
      default: shadow_src = 5'd25;
    endcase
  endfunction

endpackage

// File: rtl/ient_vector.sv
module ient_vector #(
  parameter int DW = 64,
  parameter int CAUSE_W = 6,
  parameter logic [DW-1:0] FW_START = 64'h0000_0000_F000_0000,
  parameter int CAUSE_TOC = 63
) (
  input  logic [CAUSE_W-1:0] cause,
  input  logic [DW-1:0]      base,
  output logic [DW-1:0]      front,
  output logic [DW-1:0]      back
);
  localparam int SLOT_SHIFT = 5;

  function automatic logic [DW-1:0] vec_target(input logic [CAUSE_W-1:0] c,
                                               input logic [DW-1:0] b);
    logic [DW-1:0] scaled;
    scaled = DW'(c) << SLOT_SHIFT;
    if (c == CAUSE_W'(CAUSE_TOC)) vec_target = FW_START;
    else vec_target = b + scaled;
  endfunction

  always_comb begin
    front = vec_target(cause, base);
    back  = front + DW'(4);
  end
endmodule

// File: rtl/ient_capture.sv
module ient_capture #(
  parameter int DW = 64,
  parameter bit WIDE_ARCH = 1'b1
) (
  input  logic [DW-1:0] psw_old,
  input  logic [DW-1:0] sq_front,
  input  logic [DW-1:0] sq_back,
  input  logic [DW-1:0] gva_front,
  input  logic [DW-1:0] gva_back,
  output logic [DW-1:0] cap_front,
  output logic [DW-1:0] cap_back
);
  import ient_pkg::*;
  localparam int HALF = DW / 2;

  function automatic logic [DW-1:0] upper_half(input logic [DW-1:0] v);
    upper_half = {{HALF{1'b0}}, v[DW-1:HALF]};
  endfunction

  generate
    if (WIDE_ARCH) begin : g_wide
      always_comb begin
        if (psw_old[PSW_BIT_C]) begin
          cap_front = upper_half(gva_front);
          cap_back  = upper_half(gva_back);
        end else begin
          cap_front = '0;
          cap_back  = '0;
        end
      end
    end else begin : g_narrow
      always_comb begin
        cap_front = upper_half(sq_front);
        cap_back  = upper_half(sq_back);
      end
    end
  endgenerate
endmodule

// File: rtl/ient_ctrl.sv
module ient_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       q_set,
  input  logic       is_toc,
  output ient_pkg::ient_state_e state,
  output logic [2:0] slot,
  output logic       busy,
  output logic       last_step
);
  import ient_pkg::*;
  localparam logic [2:0] LAST_SLOT = 3'(NUM_SHADOW - 1);

  ient_state_e nxt;
  logic [2:0]  slot_nxt;

  always_comb begin
    nxt = state;
    slot_nxt = slot;
    case (state)
      ST_IDLE:   if (start) nxt = ST_SAVE;
      ST_SAVE:   nxt = ST_LOAD;
      ST_LOAD:   nxt = ST_SQF;
      ST_SQF:    nxt = ST_SQB;
      ST_SQB:    nxt = ST_OQF;
      ST_OQF:    nxt = ST_OQB;
      ST_OQB: begin
        slot_nxt = '0;
        if (q_set) nxt = ST_SHADOW;
        else if (is_toc) nxt = ST_TOC_SP;
        else nxt = ST_REDIR;
      end
      ST_SHADOW: begin
        if (slot == LAST_SLOT) nxt = is_toc ? ST_TOC_SP : ST_REDIR;
        else slot_nxt = slot + 3'd1;
      end
      ST_TOC_SP: nxt = ST_TOC_OF;
      ST_TOC_OF: nxt = ST_REDIR;
      ST_REDIR:  nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      slot  <= '0;
    end else begin
      state <= nxt;
      slot  <= slot_nxt;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign last_step = (state == ST_REDIR);
endmodule

// File: rtl/ient_seq.sv
module ient_seq #(
  parameter int DW = 64,
  parameter int CAUSE_W = 6,
  parameter bit WIDE_ARCH = 1'b1,
  parameter int CAUSE_HPMC = 1,
  parameter int CAUSE_TOC = 63,
  parameter logic [DW-1:0] FW_START = 64'h0000_0000_F000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [DW-1:0]      psw_cur,
  input  logic               psw_dflt_wide,
  input  logic [DW-1:0]      iasq_front,
  input  logic [DW-1:0]      iasq_back,
  input  logic [DW-1:0]      iaoq_front,
  input  logic [DW-1:0]      iaoq_back,
  input  logic [DW-1:0]      gva_front,
  input  logic [DW-1:0]      gva_back,
  input  logic [DW-1:0]      vec_base,
  output logic [4:0]         gr_raddr,
  input  logic [DW-1:0]      gr_rdata,
  output logic               wr_en,
  output logic [4:0]         wr_sel,
  output logic [DW-1:0]      wr_data,
  output logic               redir_valid,
  output logic [DW-1:0]      redir_oq_front,
  output logic [DW-1:0]      redir_oq_back,
  output logic [DW-1:0]      redir_sq_front,
  output logic [DW-1:0]      redir_sq_back,
  output logic               busy,
  output logic               done
);
  import ient_pkg::*;

  // Events brought out for the checker.
  logic evt_accept;
  logic evt_last_step;

  ient_state_e state;
  logic [2:0]  slot;

  logic [CAUSE_W-1:0] s_cause;
  logic [DW-1:0] s_psw, s_sqf, s_sqb, s_oqf, s_oqb, s_gvf, s_gvb, s_base;
  logic s_dwide;

  logic [DW-1:0] cap_f, cap_b, vec_f, vec_b;
  logic is_toc, is_hpmc, q_set;

  function automatic logic [DW-1:0] fresh_psw(input logic dwide, input logic hpmc);
    logic [DW-1:0] p;
    p = '0;
    p[PSW_BIT_W] = dwide & WIDE_ARCH;
    p[PSW_BIT_M] = hpmc;
    fresh_psw = p;
  endfunction

  assign evt_accept = req_valid && !busy;
  assign req_ready  = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_cause <= '0; s_psw <= '0; s_dwide <= 1'b0;
      s_sqf <= '0; s_sqb <= '0; s_oqf <= '0; s_oqb <= '0;
      s_gvf <= '0; s_gvb <= '0; s_base <= '0;
    end else if (evt_accept) begin
      s_cause <= req_cause; s_psw <= psw_cur; s_dwide <= psw_dflt_wide;
      s_sqf <= iasq_front; s_sqb <= iasq_back;
      s_oqf <= iaoq_front; s_oqb <= iaoq_back;
      s_gvf <= gva_front;  s_gvb <= gva_back;
      s_base <= vec_base;
    end
  end

  assign is_toc  = (s_cause == CAUSE_W'(CAUSE_TOC));
  assign is_hpmc = (s_cause == CAUSE_W'(CAUSE_HPMC));
  assign q_set   = s_psw[PSW_BIT_Q];

  ient_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(evt_accept), .q_set(q_set),
    .is_toc(is_toc), .state(state), .slot(slot), .busy(busy),
    .last_step(evt_last_step)
  );

  ient_capture #(.DW(DW), .WIDE_ARCH(WIDE_ARCH)) u_cap (
    .psw_old(s_psw), .sq_front(s_sqf), .sq_back(s_sqb),
    .gva_front(s_gvf), .gva_back(s_gvb),
    .cap_front(cap_f), .cap_back(cap_b)
  );

  ient_vector #(.DW(DW), .CAUSE_W(CAUSE_W), .FW_START(FW_START),
                .CAUSE_TOC(CAUSE_TOC)) u_vec (
    .cause(s_cause), .base(s_base), .front(vec_f), .back(vec_b)
  );

  assign gr_raddr = shadow_src(slot);

  always_comb begin
    wr_en   = 1'b1;
    wr_sel  = TGT_IPSW;
    wr_data = '0;
    case (state)
      ST_SAVE:   begin wr_sel = TGT_IPSW; wr_data = s_psw; end
      ST_LOAD:   begin wr_sel = TGT_PSW;  wr_data = fresh_psw(s_dwide, is_hpmc); end
      ST_SQF:    begin wr_sel = TGT_SQ_F; wr_data = cap_f; end
      ST_SQB:    begin wr_sel = TGT_SQ_B; wr_data = cap_b; end
      ST_OQF:    begin wr_sel = TGT_OQ_F; wr_data = s_oqf; end
      ST_OQB:    begin wr_sel = TGT_OQ_B; wr_data = s_oqb; end
      ST_SHADOW: begin wr_sel = TGT_SHADOW0 + 5'(slot); wr_data = gr_rdata; end
      ST_TOC_SP: begin wr_sel = TGT_GR24; wr_data = cap_b; end
      ST_TOC_OF: begin wr_sel = TGT_GR25; wr_data = s_oqb; end
      default:   wr_en = 1'b0;
    endcase
  end

  assign done           = evt_last_step;
  assign redir_valid    = evt_last_step;
  assign redir_oq_front = evt_last_step ? vec_f : '0;
  assign redir_oq_back  = evt_last_step ? vec_b : '0;
  assign redir_sq_front = '0;
  assign redir_sq_back  = '0;
endmodule

// File: rtl/ient_seq_chk.sv
module ient_seq_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          busy,
  input logic          done,
  input logic          wr_en,
  input logic [4:0]    wr_sel,
  input logic [4:0]    gr_raddr,
  input logic          redir_valid,
  input logic [DW-1:0] redir_oq_front,
  input logic [DW-1:0] redir_oq_back,
  input logic [DW-1:0] redir_sq_front,
  input logic [DW-1:0] redir_sq_back,
  input logic          evt_accept
);
  a_r1_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r1_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r1_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r2_ipsw_first: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> (busy && wr_en && wr_sel == 5'd0));
  a_r6_first_shadow_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 5'd6) |-> gr_raddr == 5'd1);
  a_r9_redirect_shape: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_oq_back == redir_oq_front + DW'(4)
                     && redir_sq_front == '0 && redir_sq_back == '0));
  a_r10_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);
endmodule

bind ient_seq ient_seq_chk #(.DW(DW)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .done(done),
  .wr_en(wr_en), .wr_sel(wr_sel), .gr_raddr(gr_raddr),
  .redir_valid(redir_valid), .redir_oq_front(redir_oq_front),
  .redir_oq_back(redir_oq_back), .redir_sq_front(redir_sq_front),
  .redir_sq_back(redir_sq_back), .evt_accept(evt_accept)
);

// File: tb/ient_seq_tb_top.sv
module ient_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam logic [63:0] FW = 64'h0000_0000_F000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid = 1'b0;
  logic [5:0] req_cause = '0;
  logic [63:0] psw_cur = '0, iasq_front = '0, iasq_back = '0;
  logic [63:0] iaoq_front = '0, iaoq_back = '0, gva_front = '0, gva_back = '0;
  logic [63:0] vec_base = '0, salt = '0;
  logic psw_dflt_wide = 1'b0;

  logic req_ready, wr_en, redir_valid, busy, done;
  logic [4:0] gr_raddr, wr_sel;
  logic [63:0] gr_rdata, wr_data, r_of, r_ob, r_sf, r_sb;
  logic req_ready_n, wr_en_n, redir_valid_n, busy_n, done_n;
  logic [4:0] gr_raddr_n, wr_sel_n;
  logic [63:0] gr_rdata_n, wr_data_n, n_of, n_ob, n_sf, n_sb;

  assign gr_rdata   = {salt[63:5], gr_raddr};
  assign gr_rdata_n = {salt[63:5], gr_raddr_n};

  ient_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cause(req_cause), .psw_cur(psw_cur), .psw_dflt_wide(psw_dflt_wide),
    .iasq_front(iasq_front), .iasq_back(iasq_back), .iaoq_front(iaoq_front),
    .iaoq_back(iaoq_back), .gva_front(gva_front), .gva_back(gva_back),
    .vec_base(vec_base), .gr_raddr(gr_raddr), .gr_rdata(gr_rdata),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .redir_valid(redir_valid), .redir_oq_front(r_of), .redir_oq_back(r_ob),
    .redir_sq_front(r_sf), .redir_sq_back(r_sb), .busy(busy), .done(done));

  ient_seq #(.WIDE_ARCH(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_n),
    .req_cause(req_cause), .psw_cur(psw_cur), .psw_dflt_wide(psw_dflt_wide),
    .iasq_front(iasq_front), .iasq_back(iasq_back), .iaoq_front(iaoq_front),
    .iaoq_back(iaoq_back), .gva_front(gva_front), .gva_back(gva_back),
    .vec_base(vec_base), .gr_raddr(gr_raddr_n), .gr_rdata(gr_rdata_n),
    .wr_en(wr_en_n), .wr_sel(wr_sel_n), .wr_data(wr_data_n),
    .redir_valid(redir_valid_n), .redir_oq_front(n_of), .redir_oq_back(n_ob),
    .redir_sq_front(n_sf), .redir_sq_back(n_sb), .busy(busy_n), .done(done_n));

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_psw(input bit wide, input logic dw,
                                        input logic [5:0] c);
    logic [63:0] p = '0;
    if (wide && dw) p[27] = 1'b1;
    if (c == 6'd1) p[4] = 1'b1;
    return p;
  endfunction

  function automatic logic [63:0] m_space(input bit wide, input logic [63:0] psw,
                                          input logic [63:0] sq, input logic [63:0] gva);
    if (!wide) return {32'h0, sq[63:32]};
    return psw[18] ? {32'h0, gva[63:32]} : 64'h0;
  endfunction

  function automatic logic [63:0] m_front(input logic [5:0] c, input logic [63:0] b);
    if (c == 6'd63) return FW;
    return b + {52'h0, c, 5'h0};
  endfunction

  function automatic logic [4:0] m_src(input int k);
    case (k)
      0: return 5'd1;  1: return 5'd8;  2: return 5'd9;  3: return 5'd16;
      4: return 5'd17; 5: return 5'd24; default: return 5'd25;
    endcase
  endfunction

  task automatic run_one(input logic [5:0] c, input logic [63:0] p, input logic dw,
                         input logic [63:0] sf, input logic [63:0] sb,
                         input logic [63:0] of, input logic [63:0] ob,
                         input logic [63:0] gf, input logic [63:0] gb,
                         input logic [63:0] base, input logic [63:0] sl);
    logic [63:0] got [0:14];
    logic [63:0] got_n [0:14];
    logic [4:0] order [0:31];
    logic [4:0] raddr_seen [0:6];
    int nw = 0;
    int cyc = 0;
    int ndone = 0;
    bit fin = 0;
    logic [63:0] e_of = 0, e_ob = 0, e_sf = 0, e_sb = 0;
    logic [63:0] exp_sb;
    int e_len, k;
    bit q = p[3];
    bit toc = (c == 6'd63);
    for (int i = 0; i < 15; i++) begin got[i] = 'x; got_n[i] = 'x; end
    for (int i = 0; i < 7; i++) raddr_seen[i] = 'x;
    @(negedge clk);
    req_cause = c; psw_cur = p; psw_dflt_wide = dw; iasq_front = sf; iasq_back = sb;
    iaoq_front = of; iaoq_back = ob; gva_front = gf; gva_back = gb; vec_base = base;
    salt = sl; req_valid = 1'b1;
    @(posedge clk);
    while (!fin && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (wr_en) begin
        if (nw < 32) order[nw] = wr_sel;
        nw++;
        if (wr_sel < 15) got[wr_sel] = wr_data;
        if (wr_sel >= 6 && wr_sel <= 12) raddr_seen[wr_sel - 6] = gr_raddr;
      end
      if (wr_en_n && wr_sel_n < 15) got_n[wr_sel_n] = wr_data_n;
      if (busy && req_ready) check("R1", 1, 0, "ready while busy");
      if (done) begin
        ndone++; fin = 1;
        e_of = r_of; e_ob = r_ob; e_sf = r_sf; e_sb = r_sb;
        check("R9", {63'h0, redir_valid}, 64'h1, "redir_valid in done cycle");
      end
      // change inputs and hold request while busy: must be ignored (R1)
      if (cyc <= 3) begin
        req_cause = ~c; psw_cur = ~p; iaoq_front = ~of; iaoq_back = ~ob;
        iasq_front = ~sf; iasq_back = ~sb; gva_front = ~gf; gva_back = ~gb;
        vec_base = ~base; psw_dflt_wide = ~dw;
      end else req_valid = 1'b0;
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R1", {63'h0, busy}, 64'h0, "busy after done");
    check("R1", {63'h0, done}, 64'h0, "done single pulse");
    e_len = 7 + (q ? 7 : 0) + (toc ? 2 : 0);
    check("R10", cyc, e_len, "busy cycle count");
    check("R10", nw, e_len - 1, "write count");
    k = 0;
    for (int i = 0; i < 6; i++) begin
      if (k < 32) check("R10", order[k], i, "write order");
      k++;
    end
    if (q) for (int i = 0; i < 7; i++) begin
      if (k < 32) check("R6", order[k], 6 + i, "shadow order");
      k++;
    end
    if (toc) begin
      if (k < 32) check("R8", order[k], 13, "order gr24"); k++;
      if (k < 32) check("R8", order[k], 14, "order gr25"); k++;
    end
    check("R2", got[0], p, "saved status");
    check("R3", got[1], m_psw(1, dw, c), "new status wide variant");
    check("R3", got_n[1], m_psw(0, dw, c), "new status narrow variant");
    check("R4", got[2], m_space(1, p, sf, gf), "front space wide");
    exp_sb = m_space(1, p, sb, gb);
    check("R4", got[3], exp_sb, "back space wide");
    check("R4", got_n[2], m_space(0, p, sf, gf), "front space narrow");
    check("R4", got_n[3], m_space(0, p, sb, gb), "back space narrow");
    check("R5", got[4], of, "front offset");
    check("R5", got[5], ob, "back offset");
    if (q) for (int i = 0; i < 7; i++) begin
      check("R6", got[6 + i], {sl[63:5], m_src(i)}, "shadow data");
      check("R6", raddr_seen[i], m_src(i), "shadow read address");
    end
    if (toc) begin
      check("R8", got[13], exp_sb, "gr24 back space");
      check("R8", got[14], ob, "gr25 back offset");
    end
    if (toc) check("R8", e_of, FW, "firmware front offset");
    else check("R7", e_of, m_front(c, base), "vector front offset");
    check("R9", e_ob, m_front(c, base) + 64'd4, "back offset");
    check("R9", e_sf | e_sb, 64'h0, "spaces zero");
    check("R1", ndone, 1, "done count");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {63'h0, busy}, 0, "reset busy");
    check("R1", {63'h0, done}, 0, "reset done");
    check("R1", {63'h0, req_ready}, 1, "reset ready");
    check("R10", {63'h0, wr_en}, 0, "reset wr_en");
    // directed corners
    run_one(6'd0, 64'h0, 1'b1, 64'h1111_2222_0, 64'h3333_4444_0, 64'h100, 64'h104,
            64'hAAAA_0000_0000_0000, 64'hBBBB_0000_0000_0000, 64'h8000, 64'h1234_5678_9ABC_DEF0);
    run_one(6'd1, 64'h0004_0008, 1'b1, 64'h5555_6666_0000_0000, 64'h7777_8888_0000_0000,
            64'h2000, 64'h2004, 64'hCCCC_DDDD_0000_0000, 64'hEEEE_FFFF_0000_0000,
            64'h4000, 64'hFEDC_BA98_7654_3210);
    run_one(6'd63, 64'h0004_0008, 1'b0, 64'h0123_4567_0, 64'h89AB_CDEF_0000_0000,
            64'h3000, 64'h3004, 64'h1357_9BDF_0000_0000, 64'h2468_ACE0_0000_0000,
            64'h5000, 64'h0F0F_0F0F_0F0F_0F0F);
    run_one(6'd63, 64'h0, 1'b1, 64'h1, 64'h2, 64'h3, 64'h7, 64'h4, 64'h5,
            64'h6, 64'hF0F0_F0F0_F0F0_F0F0);
    run_one(6'd62, 64'h8, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
            64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 64'hFFFF_FFFF_0000_0000, 64'h0,
            64'hFFFF_FFFF_FFFF_FF00, 64'h0);
    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [5:0] c;
      c = 6'($urandom_range(0, 63));
      if (t % 10 == 3) c = 6'd63;
      if (t % 10 == 7) c = 6'd1;
      run_one(c, {$urandom, $urandom}, 1'($urandom), {$urandom, $urandom},
              {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom});
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule